// File: doc/BRIEF.md
# Single-Message Mailbox Buffer with Commit

This block is a one-slot hardware mailbox. A sender fills up to sixteen 32-bit buffer words through a simple word-wide write port, in any order. The message is handed over only when the sender writes the final buffer word, index 15. That word is always written, with zero when the payload does not reach it. From then on the block reports itself busy, freezes the message and exposes a byte length for it.

A receiver drains the committed message as a byte stream with a valid/ready handshake, in ascending byte order. When it is done, it pulses a release input. The release frees the slot and clears the storage, so the next message starts from zero-filled words. Any write that arrives while a message is committed and not yet released is discarded, and it raises a sticky overflow flag that only reset clears.

Top module: `mbx_msg_buffer`

## Requirements
- R1: After reset, `busy`, `ovf`, `rx_valid` and `msg_len` are all zero.
- R2: Byte k (k = 0..3) of buffer word i is carried in bits 8k+7:8k of that word and is streamed as message byte 4i+k. The stream runs from the lowest word upward.
- R3: Only an accepted write with `wr_idx` = 15 commits a message and raises `busy` on the next cycle. Writes to indices 0..14 leave `busy` low.
- R4: At commit, `msg_len` is set from word 15. If word 15 is zero, `msg_len` is 4 × (highest index in 0..14 written since the last release, plus one), or 0 when none was written. If word 15 is nonzero, `msg_len` is 60 plus the position (1..4) of its highest nonzero byte.
- R5: While `busy` is high, `rx_valid` is high for exactly `msg_len` bytes. A byte advances only on `rx_valid && rx_ready`, and `rx_data` holds steady while the receiver stalls. `rx_last` marks the final byte. A zero-length message presents no bytes.
- R6: `busy` stays high until `rx_release` is pulsed, and it falls on the next cycle. The release may come before every byte has been read. A release while idle has no effect.
- R7: Writes while `busy` is high are dropped: buffer contents and `msg_len` do not change. Each such write sets `ovf`, which then stays high until reset.
- R8: A release clears every buffer word to zero, so a word that the next message does not write streams as zero bytes.
- R9: A 61-byte message puts its final byte in bits 7:0 of word 15, with the upper bytes zero. It reports `msg_len` = 61 and streams that byte last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer word write strobe |
| wr_idx | input | 4 | Buffer word index |
| wr_data | input | 32 | Full word write data |
| rx_ready | input | 1 | Receiver accepts the presented byte |
| rx_release | input | 1 | Receiver frees the slot |
| busy | output | 1 | A committed message is held |
| ovf | output | 1 | Sticky flag for a dropped write |
| msg_len | output | 7 | Committed message length in bytes |
| rx_valid | output | 1 | Byte on `rx_data` is valid |
| rx_data | output | 8 | Streamed message byte |
| rx_last | output | 1 | Presented byte is the final one |

## Verification
The bench checks the length rule at its edges: a payload padded to a whole word, 61 bytes with a single byte in word 15, a full 64 bytes, and a commit with nothing else written. A design that counted word 15 as a full word, or counted all written words, would report 64 or a wrong multiple of four. A second commit is attempted while the slot is busy. A block that accepted it would change the streamed bytes or the length, and one that forgot the flag would drop `ovf`. A sparse message after a release exposes storage that was not cleared as nonzero bytes. Stalls on `rx_ready`, and a release part-way through the stream, catch a pointer that advances without a handshake or does not restart.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_WORDS  = 16;
    localparam int unsigned MBX_WORD_W = 32;
    typedef logic [7:0] mbx_byte_t;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned NWORDS = mbx_pkg::MBX_WORDS,
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W,
    localparam int unsigned IDX_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [IDX_W-1:0]  used_words
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    typedef struct packed {
        logic [NWORDS-1:0][WORD_W-1:0] mem;
        logic [IDX_W-1:0]              used;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mem  = '0;
            st_d.used = '0;
        end else if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
            if (wr_idx != LAST && (wr_idx + 1'b1) > st_q.used)
                st_d.used = wr_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word    = st_q.mem[rd_idx];
    assign used_words = st_q.used;

    assert_clear_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.mem == '0 && used_words == '0));
endmodule

// File: rtl/mbx_unpack.sv
module mbx_unpack #(
    parameter int unsigned NWORDS = mbx_pkg::MBX_WORDS,
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W,
    localparam int unsigned IDX_W = $clog2(NWORDS),
    localparam int unsigned BPW   = WORD_W / 8,
    localparam int unsigned SEL_W = $clog2(BPW),
    localparam int unsigned LEN_W = $clog2(NWORDS * BPW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [LEN_W-1:0]  len,
    input  logic [WORD_W-1:0] word,
    input  logic              rx_ready,
    input  logic              restart,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rx_valid,
    output mbx_pkg::mbx_byte_t rx_data,
    output logic              rx_last
);
    typedef struct packed {
        logic [LEN_W-1:0] ptr;
    } ptr_t;

    ptr_t pt_d, pt_q;
    logic [SEL_W-1:0] sel;

    assign sel      = pt_q.ptr[SEL_W-1:0];
    assign rd_idx   = pt_q.ptr[SEL_W +: IDX_W];
    assign rx_valid = active && (pt_q.ptr < len);
    assign rx_data  = word[8*sel +: 8];
    assign rx_last  = rx_valid && (pt_q.ptr == len - 1'b1);

    always_comb begin
        pt_d = pt_q;
        if (restart)
            pt_d.ptr = '0;
        else if (rx_valid && rx_ready)
            pt_d.ptr = pt_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assert_hold_when_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !restart) |=> (rx_valid && $stable(rx_data)));
    assert_stop_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last) |=> !rx_valid);
endmodule

// File: rtl/mbx_msg_buffer.sv
module mbx_msg_buffer #(
    parameter int unsigned NWORDS = mbx_pkg::MBX_WORDS,
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W,
    localparam int unsigned IDX_W = $clog2(NWORDS),
    localparam int unsigned BPW   = WORD_W / 8,
    localparam int unsigned SEL_W = $clog2(BPW),
    localparam int unsigned LEN_W = $clog2(NWORDS * BPW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rx_ready,
    input  logic              rx_release,
    output logic              busy,
    output logic              ovf,
    output logic [LEN_W-1:0]  msg_len,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    output logic              rx_last
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);
    localparam int unsigned LAST_BYTES = (NWORDS - 1) * BPW;

    typedef struct packed {
        logic             busy;
        logic             ovf;
        logic [LEN_W-1:0] len;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_take;
    logic              commit;
    logic              clr;
    logic [SEL_W:0]    top_nz;
    logic [LEN_W-1:0]  len_at_commit;
    logic [IDX_W-1:0]  used_words;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word;

    assign wr_take = wr_en && !ctl_q.busy;
    assign commit  = wr_take && (wr_idx == LAST);
    assign clr     = rx_release && ctl_q.busy;

    always_comb begin
        top_nz = '0;
        for (int b = 0; b < int'(BPW); b++) begin
            if (wr_data[8*b +: 8] != 8'h00) top_nz = (SEL_W+1)'(b + 1);
        end
        if (top_nz != '0)
            len_at_commit = LEN_W'(LAST_BYTES) + LEN_W'(top_nz);
        else
            len_at_commit = LEN_W'(used_words) * LEN_W'(BPW);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && ctl_q.busy) ctl_d.ovf = 1'b1;
        if (clr) begin
            ctl_d.busy = 1'b0;
            ctl_d.len  = '0;
        end else if (commit) begin
            ctl_d.busy = 1'b1;
            ctl_d.len  = len_at_commit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mbx_store #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_take),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .clr        (clr),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word),
        .used_words (used_words)
    );

    mbx_unpack #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (ctl_q.busy),
        .len      (ctl_q.len),
        .word     (rd_word),
        .rx_ready (rx_ready),
        .restart  (clr),
        .rd_idx   (rd_idx),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last)
    );

    assign busy    = ctl_q.busy;
    assign ovf     = ctl_q.ovf;
    assign msg_len = ctl_q.len;

    assert_no_early_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && wr_idx == LAST)) |=> !busy);
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_len <= LEN_W'(NWORDS * BPW));
    assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);
    assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_release) |=> !busy);
    assert_held_until_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rx_release) |=> (busy && $stable(msg_len)));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ovf);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

// File: tb/tb_mbx_msg_buffer.sv
`timescale 1ns/1ps
module tb_mbx_msg_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rx_ready = 1'b0;
    logic        rx_release = 1'b0;
    logic        busy, ovf, rx_valid, rx_last;
    logic [6:0]  msg_len;
    logic [7:0]  rx_data;

    int tests = 0;
    int failed = 0;

    logic [31:0] mw [16];
    bit          mbusy = 0;
    int          mused = 0;
    int          elen = 0;

    always #2 clk = ~clk;

    mbx_msg_buffer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rx_ready(rx_ready), .rx_release(rx_release), .busy(busy), .ovf(ovf),
        .msg_len(msg_len), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int calc_len();
        int top = 0;
        for (int b = 0; b < 4; b++) if (mw[15][8*b +: 8] != 8'h00) top = b + 1;
        if (top != 0) return 60 + top;
        return 4 * mused;
    endfunction

    task automatic put(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(posedge clk);
        if (!mbusy) begin
            mw[idx] = d;
            if (idx < 15 && idx + 1 > mused) mused = idx + 1;
            if (idx == 15) begin mbusy = 1; elen = calc_len(); end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic release_slot();
        @(negedge clk);
        rx_release = 1'b1;
        @(posedge clk);
        if (mbusy) begin
            for (int i = 0; i < 16; i++) mw[i] = '0;
            mused = 0; mbusy = 0; elen = 0;
        end
        @(negedge clk);
        rx_release = 1'b0;
    endtask

    task automatic drain(input bit stall, input int count);
        for (int i = 0; i < count; i++) begin
            if (stall && (i % 3 == 1)) begin
                @(negedge clk);
                rx_ready = 1'b0;
                check("R5 valid during stall", {31'd0, rx_valid}, 32'd1);
                @(posedge clk);
            end
            @(negedge clk);
            rx_ready = 1'b1;
            check("R5 valid", {31'd0, rx_valid}, 32'd1);
            check("R2 byte", {24'd0, rx_data}, {24'd0, mw[i/4][8*(i%4) +: 8]});
            check("R5 last", {31'd0, rx_last}, {31'd0, (i == elen - 1)});
            @(posedge clk);
        end
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 ovf", {31'd0, ovf}, 32'd0);
        check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R1 msg_len", {25'd0, msg_len}, 32'd0);
    endtask

    task automatic t_short();
        put(0, 32'h03020100);
        put(1, 32'h00000004);
        put(14, 32'h0);
        check("R3 no commit before word 15", {31'd0, busy}, 32'd0);
        put(15, 32'h0);
        check("R3 busy after commit", {31'd0, busy}, 32'd1);
        check("R4 padded length", {25'd0, msg_len}, 32'd60);
        drain(0, elen);
        check("R5 no byte past end", {31'd0, rx_valid}, 32'd0);
        release_slot();
        check("R6 busy cleared", {31'd0, busy}, 32'd0);
        put(0, 32'h03020100);
        put(1, 32'h00000004);
        put(15, 32'h0);
        check("R4 two word length", {25'd0, msg_len}, 32'd8);
        drain(0, elen);
        release_slot();
    endtask

    task automatic t_61();
        for (int i = 0; i < 15; i++)
            put(i, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        put(15, 32'h0000003c);
        check("R9 length 61", {25'd0, msg_len}, 32'd61);
        check("R7 no spurious ovf", {31'd0, ovf}, 32'd0);
        drain(1, elen);
        check("R9 ends after byte 60", {31'd0, rx_valid}, 32'd0);
        release_slot();
    endtask

    task automatic t_full_and_overflow();
        for (int i = 0; i < 15; i++)
            put(i, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        put(15, 32'h3f3e3d3c);
        check("R4 full length", {25'd0, msg_len}, 32'd64);
        put(0, 32'hdeadbeef);
        put(15, 32'h00000001);
        check("R7 ovf set", {31'd0, ovf}, 32'd1);
        check("R7 length kept", {25'd0, msg_len}, 32'd64);
        check("R6 still busy", {31'd0, busy}, 32'd1);
        drain(0, elen);
        release_slot();
        check("R7 ovf sticky", {31'd0, ovf}, 32'd1);
        check("R6 released", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_clear();
        put(2, 32'h0b0a0908);
        put(15, 32'h0);
        check("R4 sparse length", {25'd0, msg_len}, 32'd12);
        drain(0, elen);
        release_slot();
        put(0, 32'h11223344);
        put(3, 32'h55667788);
        put(15, 32'h0);
        drain(1, 5);
        release_slot();
        check("R6 release mid-stream", {31'd0, busy}, 32'd0);
        check("R6 no byte after release", {31'd0, rx_valid}, 32'd0);
        put(1, 32'h0);
        put(15, 32'h0);
        check("R8 cleared length", {25'd0, msg_len}, 32'd8);
        drain(0, elen);
        release_slot();
    endtask

    task automatic t_empty_and_idle_release();
        release_slot();
        check("R6 idle release ignored", {31'd0, busy}, 32'd0);
        put(15, 32'h0);
        check("R5 empty busy", {31'd0, busy}, 32'd1);
        check("R4 empty length", {25'd0, msg_len}, 32'd0);
        @(negedge clk);
        rx_ready = 1'b1;
        check("R5 empty no bytes", {31'd0, rx_valid}, 32'd0);
        @(negedge clk);
        rx_ready = 1'b0;
        release_slot();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mw[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_short();
        t_61();
        t_full_and_overflow();
        t_clear();
        t_empty_and_idle_release();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule